// File: doc/BRIEF.md
# Dual-Port Programmable Parallel Interface

This block is a bus-attached peripheral with two independent 8-bit ports, A and B. Each port has a direction register, an output latch and a control register. Each port also has two peripheral control lines. The first control line is always an input. The second line works either as an edge-sensing input or as an output.

The CPU side is a synchronous register interface with these signals:
- a select strobe
- a write/read flag
- two register-select bits
- an 8-bit write bus and an 8-bit read bus

Only four addresses exist. For each port, one control-register bit steers the port's data address to either the direction register or the data register, so six registers can be reached. Edges on the control lines set read-only flags in the control register. Those flags can raise a per-port interrupt. A read of the port data register clears them.

The peripheral side gives per-pin output values and per-pin output enables, and takes per-pin input levels. Tristate pads are outside the block. The second control line can produce an output handshake: it drops after the CPU writes the data register and rises again on the selected edge of the first line.

Top module: `dual_par_io`

## Requirements
- R1: After reset, all direction, output and control registers are zero. All pin enables are low, both interrupts are low, both second lines are inputs (enable low), and every register address reads back zero.
- R2: With control bit 2 clear, a write to the port's data address (rs 0 for A, rs 2 for B) loads the direction register, and a read there returns it. Each direction bit of 1 drives that pin's output enable high; each bit of 0 leaves the pin as an input.
- R3: With control bit 2 set, the data address reaches the output latch. The latch drives the pin output values and holds them until the latch is written again. Writes to the direction register do not change it.
- R4: With control bit 2 set, a read of the data address returns the pin input level for direction bits of 0 and the latched value for direction bits of 1.
- R5: Control register (rs 1 for A, rs 3 for B) layout:
  - bit 7: line-1 flag
  - bit 6: line-2 flag
  - bits 5:3: line-2 mode
  - bit 2: data/direction steer
  - bit 1: line-1 edge select (1 rising, 0 falling)
  - bit 0: line-1 interrupt enable
  Bits 7:6 are read-only, so writes to them are ignored. Bits 5:0 read back as written.
- R6: The line-1 flag sets on the selected edge of control line 1 only. The opposite edge leaves it clear.
- R7: With bit 5 clear, line 2 is an input. Bit 4 selects its edge (1 rising) and bit 3 enables its interrupt. The line-2 flag sets on the selected edge only. Line-2 activity does not touch the line-1 flag.
- R8: A read of the port data register (bit 2 set) clears both flags of that port. A read of the control register does not clear them.
- R9: A port's interrupt is high exactly while the line-1 flag and bit 0 are both set, or the line-2 flag and bit 3 are both set with line 2 in input mode.
- R10: With bits 5:4 = 11, line 2 is an output (enable high) whose level equals bit 3.
- R11: With bits 5:4 = 10 (handshake), line 2 is an output. It goes low in the cycle after a CPU write to the port's output latch and returns high after the selected active edge of line 1. The opposite edge leaves it low.
- R12: Register accesses and line activity on one port leave the other port's pins, line-2 output and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Access strobe, one cycle per access |
| wr_en | input | 1 | 1 = write, 0 = read during sel |
| rs | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (zero when sel is low) |
| a_pin_in | input | 8 | Port A pin levels |
| a_pin_out | output | 8 | Port A output latch |
| a_pin_oe | output | 8 | Port A per-pin output enable |
| a_ctl1 | input | 1 | Port A control line 1 |
| a_ctl2_in | input | 1 | Port A control line 2, input level |
| a_ctl2_out | output | 1 | Port A control line 2, output level |
| a_ctl2_oe | output | 1 | Port A control line 2, output enable |
| irq_a | output | 1 | Port A interrupt, active high |
| b_pin_in | input | 8 | Port B pin levels |
| b_pin_out | output | 8 | Port B output latch |
| b_pin_oe | output | 8 | Port B per-pin output enable |
| b_ctl1 | input | 1 | Port B control line 1 |
| b_ctl2_in | input | 1 | Port B control line 2, input level |
| b_ctl2_out | output | 1 | Port B control line 2, output level |
| b_ctl2_oe | output | 1 | Port B control line 2, output enable |
| irq_b | output | 1 | Port B interrupt, active high |

## Verification
The data path is swept over all 256 direction patterns on port A and a spaced subset on port B. Each pattern is paired with a distinct output value and pin value, so a read that mixes pin and latch bits incorrectly cannot agree with the arithmetic expectation. Both edge polarities are tried on each control line, which separates a correct edge select from an inverted or level-sensitive one. Flag reads through the control address and through the data address tell the clearing access apart from the harmless one. The handshake is driven with both edges of line 1 to show that only the selected edge releases it.

// File: rtl/dpio_pkg.sv
package dpio_pkg;
  localparam int CR_W       = 8;
  localparam int CR_F1      = 7;
  localparam int CR_F2      = 6;
  localparam int CR_L2_OUT  = 5;
  localparam int CR_L2_SEL  = 4;
  localparam int CR_L2_AUX  = 3;
  localparam int CR_DSEL    = 2;
  localparam int CR_E1_RISE = 1;
  localparam int CR_IE1     = 0;

  typedef enum logic [1:0] {
    L2_IN_FALL = 2'b00,
    L2_IN_RISE = 2'b01,
    L2_OUT_HS  = 2'b10,
    L2_OUT_LVL = 2'b11
  } l2_mode_e;

  typedef struct packed {
    logic wr_dir;
    logic wr_out;
    logic wr_ctrl;
    logic rd_data;
  } port_req_t;
endpackage

// File: rtl/dpio_edge.sv
module dpio_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              cur;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= cur;
  end

  assign rise = cur & ~last_q;
  assign fall = ~cur & last_q;
endmodule

// File: rtl/dpio_port.sv
module dpio_port
  import dpio_pkg::*;
#(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  port_req_t       req,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   pin_in,
  input  logic            line1,
  input  logic            line2_in,
  output logic [DW-1:0]   dir_q,
  output logic [DW-1:0]   out_q,
  output logic [CR_W-1:0] ctrl,
  output logic [DW-1:0]   data_rd,
  output logic            l2_out,
  output logic            l2_oe,
  output logic            irq
);
  logic [CR_W-3:0] cfg_q, cfg_d;
  logic [DW-1:0]   dir_d, out_d;
  logic            flag1_q, flag1_d;
  logic            flag2_q, flag2_d;
  logic            hs_q, hs_d;
  logic            l1_rise, l1_fall, l2_rise, l2_fall;
  logic            l1_hit, l2_hit;
  l2_mode_e        l2_mode;

  dpio_edge #(.STAGES(STAGES)) u_edge1 (
    .clk(clk), .rst_n(rst_n), .din(line1), .rise(l1_rise), .fall(l1_fall)
  );
  dpio_edge #(.STAGES(STAGES)) u_edge2 (
    .clk(clk), .rst_n(rst_n), .din(line2_in), .rise(l2_rise), .fall(l2_fall)
  );

  assign l2_mode = l2_mode_e'(cfg_q[CR_L2_OUT:CR_L2_SEL]);

  // next-state logic
  always_comb begin
    dir_d = req.wr_dir  ? wdata : dir_q;
    out_d = req.wr_out  ? wdata : out_q;
    cfg_d = req.wr_ctrl ? wdata[CR_W-3:0] : cfg_q;

    l1_hit = cfg_q[CR_E1_RISE] ? l1_rise : l1_fall;
    l2_hit = 1'b0;
    if (l2_mode == L2_IN_RISE) l2_hit = l2_rise;
    if (l2_mode == L2_IN_FALL) l2_hit = l2_fall;

    // an arriving edge wins over a clearing read
    if (l1_hit)           flag1_d = 1'b1;
    else if (req.rd_data) flag1_d = 1'b0;
    else                  flag1_d = flag1_q;

    if (cfg_q[CR_L2_OUT]) flag2_d = 1'b0;
    else if (l2_hit)      flag2_d = 1'b1;
    else if (req.rd_data) flag2_d = 1'b0;
    else                  flag2_d = flag2_q;

    if (req.wr_out)  hs_d = 1'b0;
    else if (l1_hit) hs_d = 1'b1;
    else             hs_d = hs_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      cfg_q   <= '0;
      flag1_q <= 1'b0;
      flag2_q <= 1'b0;
      hs_q    <= 1'b1;
    end else begin
      dir_q   <= dir_d;
      out_q   <= out_d;
      cfg_q   <= cfg_d;
      flag1_q <= flag1_d;
      flag2_q <= flag2_d;
      hs_q    <= hs_d;
    end
  end

  assign ctrl    = {flag1_q, flag2_q, cfg_q};
  assign data_rd = (pin_in & ~dir_q) | (out_q & dir_q);
  assign l2_oe   = cfg_q[CR_L2_OUT];
  assign l2_out  = (l2_mode == L2_OUT_LVL) ? cfg_q[CR_L2_AUX] : hs_q;
  assign irq     = (flag1_q & cfg_q[CR_IE1]) |
                   (flag2_q & cfg_q[CR_L2_AUX] & ~cfg_q[CR_L2_OUT]);
endmodule

// File: rtl/dual_par_io.sv
module dual_par_io
  import dpio_pkg::*;
#(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr_en,
  input  logic [1:0]    rs,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] a_pin_in,
  output logic [DW-1:0] a_pin_out,
  output logic [DW-1:0] a_pin_oe,
  input  logic          a_ctl1,
  input  logic          a_ctl2_in,
  output logic          a_ctl2_out,
  output logic          a_ctl2_oe,
  output logic          irq_a,
  input  logic [DW-1:0] b_pin_in,
  output logic [DW-1:0] b_pin_out,
  output logic [DW-1:0] b_pin_oe,
  input  logic          b_ctl1,
  input  logic          b_ctl2_in,
  output logic          b_ctl2_out,
  output logic          b_ctl2_oe,
  output logic          irq_b
);
  localparam int NPORT = 2;

  logic [DW-1:0]   pin_in_v [NPORT];
  logic [DW-1:0]   dir_vec  [NPORT];
  logic [DW-1:0]   out_vec  [NPORT];
  logic [DW-1:0]   drd_vec  [NPORT];
  logic [CR_W-1:0] ctrl_vec [NPORT];
  logic            l1_v     [NPORT];
  logic            l2i_v    [NPORT];
  logic            l2o_v    [NPORT];
  logic            l2e_v    [NPORT];
  logic            irq_v    [NPORT];
  port_req_t       req_v    [NPORT];
  logic            acc_wr, acc_rd;
  logic [DW-1:0]   rd_mux;

  assign acc_wr = sel & wr_en;
  assign acc_rd = sel & ~wr_en;

  assign pin_in_v[0] = a_pin_in;
  assign pin_in_v[1] = b_pin_in;
  assign l1_v[0]     = a_ctl1;
  assign l1_v[1]     = b_ctl1;
  assign l2i_v[0]    = a_ctl2_in;
  assign l2i_v[1]    = b_ctl2_in;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic hit, steer;
      assign hit   = (rs[1] == p[0]);
      assign steer = ctrl_vec[p][CR_DSEL];

      always_comb begin
        req_v[p].wr_dir  = acc_wr & hit & ~rs[0] & ~steer;
        req_v[p].wr_out  = acc_wr & hit & ~rs[0] &  steer;
        req_v[p].wr_ctrl = acc_wr & hit &  rs[0];
        req_v[p].rd_data = acc_rd & hit & ~rs[0] &  steer;
      end

      dpio_port #(.DW(DW), .STAGES(STAGES)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_v[p]),
        .wdata    (wdata),
        .pin_in   (pin_in_v[p]),
        .line1    (l1_v[p]),
        .line2_in (l2i_v[p]),
        .dir_q    (dir_vec[p]),
        .out_q    (out_vec[p]),
        .ctrl     (ctrl_vec[p]),
        .data_rd  (drd_vec[p]),
        .l2_out   (l2o_v[p]),
        .l2_oe    (l2e_v[p]),
        .irq      (irq_v[p])
      );
    end
  endgenerate

  always_comb begin
    if (rs[0])                         rd_mux = DW'(ctrl_vec[rs[1]]);
    else if (ctrl_vec[rs[1]][CR_DSEL]) rd_mux = drd_vec[rs[1]];
    else                               rd_mux = dir_vec[rs[1]];
  end

  assign rdata = sel ? rd_mux : '0;

  assign a_pin_out  = out_vec[0];
  assign a_pin_oe   = dir_vec[0];
  assign a_ctl2_out = l2o_v[0];
  assign a_ctl2_oe  = l2e_v[0];
  assign irq_a      = irq_v[0];
  assign b_pin_out  = out_vec[1];
  assign b_pin_oe   = dir_vec[1];
  assign b_ctl2_out = l2o_v[1];
  assign b_ctl2_oe  = l2e_v[1];
  assign irq_b      = irq_v[1];
endmodule

// File: rtl/dual_par_io_chk.sv
module dual_par_io_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       wr_en,
  input logic [1:0] rs,
  input logic [7:0] a_pin_out,
  input logic [7:0] a_pin_oe,
  input logic [7:0] b_pin_out,
  input logic [7:0] b_pin_oe,
  input logic       a_ctl2_out,
  input logic       a_ctl2_oe,
  input logic       irq_a,
  input logic       irq_b,
  input logic [7:0] a_ctrl,
  input logic [7:0] b_ctrl
);
  // R1: reset holds every pin as an input and interrupts quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (a_pin_oe == 8'h00 && b_pin_oe == 8'h00 && !irq_a && !irq_b));

  // R3: output latch only moves on a write to its port's data address
  a_r3_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr_en && rs == 2'd0) |=> $stable(a_pin_out));
  a_r3_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr_en && rs == 2'd2) |=> $stable(b_pin_out));

  // R11: a latch write in handshake mode drives line 2 low next cycle
  a_r11_hs_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && rs == 2'd0 && a_ctrl[2] && a_ctrl[5:4] == 2'b10)
    |=> (a_ctl2_oe && !a_ctl2_out));

  // R9: no interrupt without a pending flag
  a_r9_irq_flag_a: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> (a_ctrl[7] || a_ctrl[6]));
  a_r9_irq_flag_b: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b |-> (b_ctrl[7] || b_ctrl[6]));
endmodule

bind dual_par_io dual_par_io_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel),
  .wr_en      (wr_en),
  .rs         (rs),
  .a_pin_out  (a_pin_out),
  .a_pin_oe   (a_pin_oe),
  .b_pin_out  (b_pin_out),
  .b_pin_oe   (b_pin_oe),
  .a_ctl2_out (a_ctl2_out),
  .a_ctl2_oe  (a_ctl2_oe),
  .irq_a      (irq_a),
  .irq_b      (irq_b),
  .a_ctrl     (ctrl_vec[0]),
  .b_ctrl     (ctrl_vec[1])
);

// File: tb/dual_par_io_tb_top.sv
`timescale 1ns/1ps
module dual_par_io_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel, wr_en;
  logic [1:0] rs;
  logic [7:0] wdata, rdata;
  logic [7:0] a_pin_in, a_pin_out, a_pin_oe;
  logic [7:0] b_pin_in, b_pin_out, b_pin_oe;
  logic       a_ctl1, a_ctl2_in, a_ctl2_out, a_ctl2_oe, irq_a;
  logic       b_ctl1, b_ctl2_in, b_ctl2_out, b_ctl2_oe, irq_b;

  int vectors = 0;
  int miscomp = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  dual_par_io dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rs(rs),
    .wdata(wdata), .rdata(rdata),
    .a_pin_in(a_pin_in), .a_pin_out(a_pin_out), .a_pin_oe(a_pin_oe),
    .a_ctl1(a_ctl1), .a_ctl2_in(a_ctl2_in), .a_ctl2_out(a_ctl2_out),
    .a_ctl2_oe(a_ctl2_oe), .irq_a(irq_a),
    .b_pin_in(b_pin_in), .b_pin_out(b_pin_out), .b_pin_oe(b_pin_oe),
    .b_ctl1(b_ctl1), .b_ctl2_in(b_ctl2_in), .b_ctl2_out(b_ctl2_out),
    .b_ctl2_oe(b_ctl2_oe), .irq_b(irq_b)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b1; rs = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b0; rs = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic sweep(input int p, input int step);
    logic [1:0] db, cb;
    logic [7:0] prev, o, pin, r, oth_out, oth_oe;
    db = (p == 1) ? 2'd2 : 2'd0;
    cb = db + 2'd1;
    prev = (p == 1) ? b_pin_out : a_pin_out;
    oth_out = (p == 1) ? a_pin_out : b_pin_out;
    oth_oe  = (p == 1) ? a_pin_oe  : b_pin_oe;
    for (int d = 0; d < 256; d += step) begin
      bus_wr(cb, 8'h00);
      bus_wr(db, 8'(d));
      chk("R3 latch held across direction write", (p == 1) ? b_pin_out : a_pin_out, prev);
      chk("R2 output enable", (p == 1) ? b_pin_oe : a_pin_oe, 8'(d));
      bus_rd(db, r);
      chk("R2 direction readback", r, 8'(d));
      bus_wr(cb, 8'h04);
      o   = 8'(d) ^ 8'hA5;
      pin = 8'(d * 7 + 3);
      if (p == 1) b_pin_in = pin; else a_pin_in = pin;
      bus_wr(db, o);
      chk("R3 latch drives pins", (p == 1) ? b_pin_out : a_pin_out, o);
      bus_rd(db, r);
      chk("R4 mixed data read", r, (pin & ~8'(d)) | (o & 8'(d)));
      chk("R12 other port outputs", (p == 1) ? a_pin_out : b_pin_out, oth_out);
      chk("R12 other port enables", (p == 1) ? a_pin_oe : b_pin_oe, oth_oe);
      prev = o;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      miscomp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; sel = 1'b0; wr_en = 1'b0; rs = 2'd0; wdata = 8'h00;
    a_pin_in = 8'h00; b_pin_in = 8'h00;
    a_ctl1 = 1'b0; a_ctl2_in = 1'b0; b_ctl1 = 1'b0; b_ctl2_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 a enables", a_pin_oe, 8'h00);
    chk("R1 b enables", b_pin_oe, 8'h00);
    chk("R1 a latch", a_pin_out, 8'h00);
    chk("R1 irq", {6'd0, irq_a, irq_b}, 8'h00);
    chk("R1 line2 enables", {6'd0, a_ctl2_oe, b_ctl2_oe}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      bus_rd(2'(a), r);
      chk("R1 register reads zero", r, 8'h00);
    end

    // R2 R3 R4 R12 data path sweeps
    sweep(0, 1);
    sweep(1, 17);

    // R5 read-only flag bits, R10 manual line-2 level
    bus_wr(2'd1, 8'hC4);
    bus_rd(2'd1, r);
    chk("R5 flag bits ignore writes", r, 8'h04);
    bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, r);
    chk("R5 readback of writable bits", r, 8'h3F);
    chk("R10 manual high", {6'd0, a_ctl2_oe, a_ctl2_out}, 8'h03);
    bus_wr(2'd1, 8'h34);
    chk("R10 manual low", {6'd0, a_ctl2_oe, a_ctl2_out}, 8'h02);
    chk("R12 b line2 untouched", {6'd0, b_ctl2_oe, irq_b}, 8'h00);

    // R6 line-1 edge selection
    for (int es = 0; es < 2; es++) begin
      bus_wr(2'd1, 8'h04 | 8'(es << 1));
      bus_rd(2'd0, r);
      a_ctl1 = 1'b1; settle();
      bus_rd(2'd1, r);
      chk("R6 flag1 after rising edge", r & 8'h80, (es == 1) ? 8'h80 : 8'h00);
      bus_rd(2'd0, r);
      a_ctl1 = 1'b0; settle();
      bus_rd(2'd1, r);
      chk("R6 flag1 after falling edge", r & 8'h80, (es == 0) ? 8'h80 : 8'h00);
      bus_rd(2'd0, r);
    end

    // R7 line-2 input edge selection
    for (int es = 0; es < 2; es++) begin
      bus_wr(2'd1, 8'h04 | 8'(es << 4));
      bus_rd(2'd0, r);
      a_ctl2_in = 1'b1; settle();
      bus_rd(2'd1, r);
      chk("R7 flag2 after rising edge", r & 8'hC0, (es == 1) ? 8'h40 : 8'h00);
      bus_rd(2'd0, r);
      a_ctl2_in = 1'b0; settle();
      bus_rd(2'd1, r);
      chk("R7 flag2 after falling edge", r & 8'hC0, (es == 0) ? 8'h40 : 8'h00);
      bus_rd(2'd0, r);
    end

    // R8 which read clears the flags
    bus_wr(2'd1, 8'h06);
    a_ctl1 = 1'b1; settle();
    bus_rd(2'd1, r);
    bus_rd(2'd1, r);
    chk("R8 control read keeps flag", r & 8'h80, 8'h80);
    bus_rd(2'd0, r);
    bus_rd(2'd1, r);
    chk("R8 data read clears flag1", r & 8'hC0, 8'h00);
    bus_wr(2'd1, 8'h14);
    a_ctl2_in = 1'b1; settle();
    bus_rd(2'd0, r);
    bus_rd(2'd1, r);
    chk("R8 data read clears flag2", r & 8'hC0, 8'h00);

    // R9 interrupt gating
    a_ctl1 = 1'b0; settle();
    bus_wr(2'd1, 8'h07);
    a_ctl1 = 1'b1; settle();
    chk("R9 irq with flag1 enabled", {7'd0, irq_a}, 8'h01);
    chk("R12 b irq quiet", {7'd0, irq_b}, 8'h00);
    bus_rd(2'd0, r);
    chk("R9 irq drops after clear", {7'd0, irq_a}, 8'h00);
    bus_wr(2'd1, 8'h06);
    a_ctl1 = 1'b0; settle();
    a_ctl1 = 1'b1; settle();
    bus_rd(2'd1, r);
    chk("R9 flag set without enable", r & 8'h80, 8'h80);
    chk("R9 no irq without enable", {7'd0, irq_a}, 8'h00);
    bus_rd(2'd0, r);
    bus_wr(2'd1, 8'h1C);
    a_ctl2_in = 1'b0; settle();
    a_ctl2_in = 1'b1; settle();
    chk("R9 irq with flag2 enabled", {7'd0, irq_a}, 8'h01);
    bus_rd(2'd0, r);
    chk("R9 irq drops after flag2 clear", {7'd0, irq_a}, 8'h00);

    // R11 output handshake, port A
    a_ctl1 = 1'b0; settle();
    bus_wr(2'd1, 8'h26);
    chk("R11 line2 is output", {7'd0, a_ctl2_oe}, 8'h01);
    bus_wr(2'd0, 8'h5A);
    chk("R11 low after latch write", {7'd0, a_ctl2_out}, 8'h00);
    a_ctl1 = 1'b1;
    @(negedge clk);
    chk("R11 still low before edge is seen", {7'd0, a_ctl2_out}, 8'h00);
    settle();
    chk("R11 high after rising edge", {7'd0, a_ctl2_out}, 8'h01);
    bus_wr(2'd0, 8'h11);
    chk("R11 low after second write", {7'd0, a_ctl2_out}, 8'h00);
    a_ctl1 = 1'b0; settle();
    chk("R11 falling edge ignored", {7'd0, a_ctl2_out}, 8'h00);
    a_ctl1 = 1'b1; settle();
    chk("R11 high after next rising edge", {7'd0, a_ctl2_out}, 8'h01);

    // R11 on port B, R12 port A unchanged
    bus_wr(2'd3, 8'h26);
    bus_wr(2'd2, 8'h77);
    chk("R11 b low after write", {7'd0, b_ctl2_out}, 8'h00);
    chk("R12 a line2 unchanged", {7'd0, a_ctl2_out}, 8'h01);
    chk("R12 a latch unchanged", a_pin_out, 8'h11);
    b_ctl1 = 1'b1; settle();
    chk("R11 b high after rising edge", {7'd0, b_ctl2_out}, 8'h01);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule